// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog

This block is a watchdog timer driven through a single 32-bit control word. Each write carries a reload count, a run/stop command and a 7-bit key. Once the stored command is "run", software must present, on every later write, the bitwise inverse of the key it wrote last time. A write with any other key changes nothing. This stops a runaway program from servicing the watchdog with a fixed repeated store.

The counter decrements on cycles where an external slow tick enable is high. When it reaches zero for the first time, the block raises a non-maskable interrupt and reloads a short grace count. If the grace count also runs out before software services the watchdog, the block emits a one-cycle system reset request and stops. A status word shows the live count, whether the counter is running, and the escalation stage.

Top module: `keyed_wdt`

## Requirements
- R1: Control word layout: bits [7:0] hold the reload count, bit 8 holds the command (1 = run, 0 = stop), and bits [15:9] hold the key. Status word layout: stat_o[8:0] is the current count, stat_o[9] is the running flag, and stat_o[11:10] is the stage (0 = idle, 1 = NMI grace, 2 = reset issued). All other status bits read 0.
- R2: After reset, nmi_o = 0, rst_req_o = 0 and stat_o = 0. The first write after reset is accepted whatever its key.
- R3: While the stored command is run, a write whose key is not the bitwise complement of the stored key is ignored. Count, running flag, stage and nmi_o all keep their values.
- R4: An accepted write loads the count field into the counter and stores the new key and command.
- R5: A count field of 0 loads 256.
- R6: An accepted write with command 0 stops the counter, so the count holds through ticks. Once the stored command is stop, any key is accepted.
- R7: While running, the counter decreases by one only on cycles where tick_i is high. Without a tick it holds its value.
- R8: When the count reaches zero in stage 0, nmi_o goes to 1, the count reloads to 10, and the stage becomes 1.
- R9: When the count reaches zero in stage 1, rst_req_o is high for exactly one cycle. The counter then stops with count 0 and stage 2, and it stays stopped through later ticks.
- R10: An accepted write clears nmi_o and returns the stage to 0.
- R11: If an accepted write and an expiring tick fall in the same cycle, the write wins. The count takes the new value and no NMI is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Control word write strobe |
| wdata_i | input | 32 | Control word write data |
| tick_i | input | 1 | Slow tick enable for the countdown |
| nmi_o | output | 1 | Non-maskable interrupt, first-stage expiry |
| rst_req_o | output | 1 | One-cycle system reset request, second-stage expiry |
| stat_o | output | 32 | Status: count, running flag, stage |

## Verification
Servicing and expiry can land in the same clock cycle: a software write can arrive on the very tick that drives the count from 1 to 0. The bench counts the count down to 1, then drives a correctly keyed write together with tick_i in one cycle. It then checks that the status shows the newly written count in stage 0 and that nmi_o stays low. A second collision check drives a write with the wrong key while the grace stage is running, and confirms that the NMI and the stage are not disturbed.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   typedef enum logic [1:0] {
      STG_IDLE  = 2'd0,
      STG_GRACE = 2'd1,
      STG_FIRED = 2'd2
   } wdt_stage_e;

   localparam int unsigned CMD_BIT = 8;
   localparam int unsigned KEY_LSB = 9;
endpackage

// File: rtl/wdt_key_gate.sv
module wdt_key_gate
   import wdt_pkg::*;
#(
   parameter int unsigned CNT_W    = 8,
   parameter int unsigned KEY_W    = 7,
   parameter bit          KEY_LOCK = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             we_i,
   input  logic [31:0]      wdata_i,
   output logic             load_o,
   output logic             load_cmd_o,
   output logic [CNT_W:0]   load_cnt_o
);
   localparam int unsigned CW = CNT_W + 1;

   logic [KEY_W-1:0] key_q;
   logic             armed_q;
   logic [KEY_W-1:0] new_key;
   logic [CNT_W-1:0] new_cnt;
   logic             key_ok;

   assign new_key = wdata_i[KEY_LSB +: KEY_W];
   assign new_cnt = wdata_i[CNT_W-1:0];

   generate
      if (KEY_LOCK) begin : g_lock
         assign key_ok = !armed_q || (new_key == ~key_q);
      end else begin : g_open
         assign key_ok = 1'b1;
      end
   endgenerate

   assign load_o     = we_i && key_ok;
   assign load_cmd_o = wdata_i[CMD_BIT];
   assign load_cnt_o = (new_cnt == '0) ? CW'(1 << CNT_W) : {1'b0, new_cnt};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         key_q   <= '0;
         armed_q <= 1'b0;
      end else if (load_o) begin
         key_q   <= new_key;
         armed_q <= wdata_i[CMD_BIT];
      end
   end

   p_wrong_key_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (KEY_LOCK && we_i && armed_q && new_key != ~key_q)
         |=> ($stable(key_q) && $stable(armed_q)));

   p_armed_follows_cmd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_o |=> (armed_q == $past(wdata_i[CMD_BIT])));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
   import wdt_pkg::*;
#(
   parameter int unsigned CNT_W = 8,
   parameter int unsigned GRACE = 10
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic           load_i,
   input  logic           load_cmd_i,
   input  logic [CNT_W:0] load_cnt_i,
   input  logic           tick_i,
   output logic [CNT_W:0] cnt_o,
   output logic           run_o,
   output wdt_stage_e     stage_o,
   output logic           nmi_o,
   output logic           rst_req_o
);
   localparam int unsigned CW = CNT_W + 1;
   localparam logic [CW-1:0] GRACE_V = CW'(GRACE);

   logic [CW-1:0] cnt_q;
   logic          run_q;
   wdt_stage_e    stage_q;
   logic          nmi_q;
   logic          rreq_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q   <= '0;
         run_q   <= 1'b0;
         stage_q <= STG_IDLE;
         nmi_q   <= 1'b0;
         rreq_q  <= 1'b0;
      end else begin
         rreq_q <= 1'b0;
         if (load_i) begin
            cnt_q   <= load_cnt_i;
            run_q   <= load_cmd_i;
            stage_q <= STG_IDLE;
            nmi_q   <= 1'b0;
         end else if (run_q && tick_i) begin
            if (cnt_q > CW'(1)) begin
               cnt_q <= cnt_q - CW'(1);
            end else if (stage_q == STG_IDLE) begin
               cnt_q   <= GRACE_V;
               stage_q <= STG_GRACE;
               nmi_q   <= 1'b1;
            end else begin
               cnt_q   <= '0;
               run_q   <= 1'b0;
               stage_q <= STG_FIRED;
               rreq_q  <= 1'b1;
            end
         end
      end
   end

   assign cnt_o     = cnt_q;
   assign run_o     = run_q;
   assign stage_o   = stage_q;
   assign nmi_o     = nmi_q;
   assign rst_req_o = rreq_q;

   p_hold_no_tick_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!load_i && !(run_q && tick_i)) |=> $stable(cnt_q));

   p_nmi_grace_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(nmi_q) |-> (cnt_q == GRACE_V && stage_q == STG_GRACE));

   p_rst_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rreq_q |=> !rreq_q);

   p_rst_stops_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rreq_q |-> (!run_q && stage_q == STG_FIRED));

   p_service_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |=> (!nmi_q && stage_q == STG_IDLE));
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
   import wdt_pkg::*;
#(
   parameter int unsigned CNT_W    = 8,
   parameter int unsigned KEY_W    = 7,
   parameter int unsigned GRACE    = 10,
   parameter bit          KEY_LOCK = 1'b1
) (
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        we_i,
   input  logic [31:0] wdata_i,
   input  logic        tick_i,
   output logic        nmi_o,
   output logic        rst_req_o,
   output logic [31:0] stat_o
);
   localparam int unsigned CW = CNT_W + 1;

   generate
      if (CNT_W < 1 || CNT_W > CMD_BIT) begin : g_bad_cnt
         $error("keyed_wdt: CNT_W must lie in 1..8");
      end
      if (KEY_W < 1 || KEY_LSB + KEY_W > 32) begin : g_bad_key
         $error("keyed_wdt: key field does not fit the control word");
      end
      if (GRACE < 1 || GRACE > (1 << CNT_W)) begin : g_bad_grace
         $error("keyed_wdt: GRACE out of range");
      end
   endgenerate

   logic          load;
   logic          load_cmd;
   logic [CW-1:0] load_cnt;
   logic [CW-1:0] cnt;
   logic          run;
   wdt_stage_e    stage;

   wdt_key_gate #(
      .CNT_W   (CNT_W),
      .KEY_W   (KEY_W),
      .KEY_LOCK(KEY_LOCK)
   ) u_gate (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .we_i      (we_i),
      .wdata_i   (wdata_i),
      .load_o    (load),
      .load_cmd_o(load_cmd),
      .load_cnt_o(load_cnt)
   );

   wdt_counter #(
      .CNT_W(CNT_W),
      .GRACE(GRACE)
   ) u_cnt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (load),
      .load_cmd_i(load_cmd),
      .load_cnt_i(load_cnt),
      .tick_i    (tick_i),
      .cnt_o     (cnt),
      .run_o     (run),
      .stage_o   (stage),
      .nmi_o     (nmi_o),
      .rst_req_o (rst_req_o)
   );

   always_comb begin
      stat_o          = '0;
      stat_o[CW-1:0]  = cnt;
      stat_o[9]       = run;
      stat_o[11:10]   = stage;
   end

   p_nmi_only_when_running_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(nmi_o) |-> $past(run));
endmodule

// File: tb/tb_keyed_wdt.sv
module tb_keyed_wdt;
   logic        clk_i = 1'b0;
   logic        rst_ni = 1'b0;
   logic        we_i = 1'b0;
   logic [31:0] wdata_i = '0;
   logic        tick_i = 1'b0;
   logic        nmi_o;
   logic        rst_req_o;
   logic [31:0] stat_o;

   int checks = 0;
   int errors = 0;

   always #2 clk_i = ~clk_i;

   keyed_wdt dut (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .we_i     (we_i),
      .wdata_i  (wdata_i),
      .tick_i   (tick_i),
      .nmi_o    (nmi_o),
      .rst_req_o(rst_req_o),
      .stat_o   (stat_o)
   );

   function automatic logic [31:0] cw(input logic [6:0] key, input logic cmd,
                                      input logic [7:0] cnt);
      return {16'h0, key, cmd, cnt};
   endfunction

   function automatic logic [31:0] st(input int cnt, input logic run, input int stg);
      logic [31:0] v;
      v        = '0;
      v[8:0]   = 9'(cnt);
      v[9]     = run;
      v[11:10] = 2'(stg);
      return v;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // one cycle: inputs set after a falling edge, results sampled at the next one
   task automatic step(input logic we, input logic [31:0] d, input logic tk);
      we_i    = we;
      wdata_i = d;
      tick_i  = tk;
      @(negedge clk_i);
      we_i   = 1'b0;
      tick_i = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) step(1'b0, '0, 1'b1);
   endtask

   task automatic t_reset();
      chk("R2 nmi", 32'(nmi_o), 0);
      chk("R2 rst_req", 32'(rst_req_o), 0);
      chk("R2 stat", stat_o, 0);
   endtask

   task automatic t_first_write_and_count();
      step(1'b1, cw(7'h15, 1'b1, 8'd5), 1'b0);
      chk("R2 R4 any key after reset", stat_o, st(5, 1, 0));
      ticks(2);
      chk("R7 decrement on tick", stat_o, st(3, 1, 0));
      step(1'b0, '0, 1'b0); step(1'b0, '0, 1'b0); step(1'b0, '0, 1'b0);
      chk("R7 hold without tick", stat_o, st(3, 1, 0));
   endtask

   task automatic t_key_rules();
      step(1'b1, cw(7'h15, 1'b1, 8'd100), 1'b0);
      chk("R3 same key ignored", stat_o, st(3, 1, 0));
      step(1'b1, cw(7'h6A, 1'b1, 8'd0), 1'b0);
      chk("R4 R5 complement key, zero is 256", stat_o, st(256, 1, 0));
   endtask

   task automatic t_stop();
      step(1'b1, cw(7'h15, 1'b0, 8'd7), 1'b0);
      chk("R6 stop load", stat_o, st(7, 0, 0));
      ticks(4);
      chk("R6 stopped holds", stat_o, st(7, 0, 0));
   endtask

   task automatic t_escalate();
      step(1'b1, cw(7'h01, 1'b1, 8'd3), 1'b0);
      chk("R6 any key when stopped", stat_o, st(3, 1, 0));
      ticks(3);
      chk("R8 nmi raised", 32'(nmi_o), 1);
      chk("R8 grace reload", stat_o, st(10, 1, 1));
      step(1'b1, cw(7'h55, 1'b1, 8'd9), 1'b0);
      chk("R3 wrong key keeps nmi", 32'(nmi_o), 1);
      chk("R3 wrong key keeps stage", stat_o, st(10, 1, 1));
      ticks(9);
      chk("R9 no reset yet", 32'(rst_req_o), 0);
      ticks(1);
      chk("R9 reset request", 32'(rst_req_o), 1);
      chk("R9 stopped fired", stat_o, st(0, 0, 2));
      step(1'b0, '0, 1'b1);
      chk("R9 single pulse", 32'(rst_req_o), 0);
      ticks(5);
      chk("R9 stays stopped", stat_o, st(0, 0, 2));
   endtask

   task automatic t_service();
      step(1'b1, cw(7'h7E, 1'b1, 8'd4), 1'b0);
      chk("R10 nmi cleared", 32'(nmi_o), 0);
      chk("R10 stage cleared", stat_o, st(4, 1, 0));
   endtask

   task automatic t_collision();
      ticks(3);
      chk("R11 count at one", stat_o, st(1, 1, 0));
      step(1'b1, cw(7'h01, 1'b1, 8'd6), 1'b1);
      chk("R11 write wins count", stat_o, st(6, 1, 0));
      chk("R11 no nmi", 32'(nmi_o), 0);
   endtask

   task automatic t_layout();
      chk("R1 upper status bits zero", {20'h0, stat_o[31:12]}, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk_i);
      rst_ni = 1'b1;
      @(negedge clk_i);
      t_reset();
      t_first_write_and_count();
      t_key_rules();
      t_stop();
      t_escalate();
      t_service();
      t_collision();
      t_layout();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk_i);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule